// File: doc/BRIEF.md
# Double-Precision Invalid-Operation Classifier

This block sits beside a binary64 arithmetic pipeline and decides, for each issued operation, whether the operation is invalid and what the pipeline should write back. It looks at the operation code and at up to three 64-bit operands. It then reports which invalid-operation cause applies, if any, and returns a select code. The select code tells the write-back stage to keep the arithmetic result, to substitute the default quiet NaN, or to substitute a signaling-NaN operand that has been made quiet. The value to substitute is supplied with the code.

The cause-specific checks take precedence over the signaling-NaN check. When no specific cause applies, a signaling-NaN operand still raises its flag, and the result is that operand with its quiet bit set. The result is never zero and never a freshly made default NaN. All outputs are registered and appear one cycle after the input strobe.

Top module: `fpinv_classifier`

## Requirements
- R1: For add (op 0), the infinity-difference flag rises when both operands are infinite with opposite signs. For subtract (op 1), it rises when both operands are infinite with equal signs.
- R2: For multiply (op 2) and for the fused multiply-add codes 8 to 11, the infinity-times-zero flag rises when one of operands a and b is infinite and the other is zero, in either order. Operand c plays no part in this test.
- R3: For divide (op 3), the infinity-over-infinity flag rises when both operands are infinite. When that test fails, the zero-over-zero flag rises when both operands are zero.
- R4: For square root (op 4) and reciprocal square root (op 5), the negative-operand flag rises when the sign bit of a is set and a is not a zero of either sign. This includes negative NaNs. Negative zero raises nothing.
- R5: Whenever a cause-specific flag rises, exactly one flag is set, the signaling-NaN flag stays low, res_sel_o is 2'b01 and res_val_o is 64'h7FF8_0000_0000_0000.
- R6: An operand is a signaling NaN when its exponent is all ones, its fraction is nonzero and fraction bit 51 is clear. When no cause applies and a used operand is a signaling NaN, the signaling-NaN flag rises. In that case res_sel_o is 2'b10 and res_val_o is that operand with bit 51 set and every other bit unchanged.
- R7: When several used operands are signaling NaNs, the lowest-numbered one (a, then b, then c) is propagated. Quiet NaNs never win over a signaling NaN.
- R8: Only the operands an op uses are examined. Binary ops 0 to 3 use a and b. Unary ops 4 to 7 (square root, reciprocal square root, reciprocal, round to single) use a. Codes 8 to 11 use a, b and c. A signaling NaN on an unused operand has no effect.
- R9: When no cause applies and no used operand is a signaling NaN, all flags are zero, res_sel_o is 2'b00 and res_val_o is zero. Quiet-NaN operands alone raise no flag.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. valid_o follows valid_i with one cycle of delay. While valid_o is low, and after reset, all flags, res_sel_o and res_val_o are zero.
- R11: Operation codes 12 to 15 are unassigned. They raise no flag and give res_sel_o 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| src_a_i | input | 64 | Operand a |
| src_b_i | input | 64 | Operand b |
| src_c_i | input | 64 | Operand c (addend of fused ops) |
| valid_o | output | 1 | Registered strobe |
| inv_snan_o | output | 1 | Signaling-NaN operand |
| inv_inf_sub_o | output | 1 | Infinity minus infinity |
| inv_inf_mul_zero_o | output | 1 | Infinity times zero |
| inv_inf_div_o | output | 1 | Infinity over infinity |
| inv_zero_div_o | output | 1 | Zero over zero |
| inv_neg_sqrt_o | output | 1 | Root of a negative nonzero value |
| res_sel_o | output | 2 | 00 keep result, 01 default NaN, 10 propagated NaN |
| res_val_o | output | 64 | Substitute result value |

## Verification
Assertions check on every cycle the properties that hold for any operation. The cause flags are mutually exclusive. Any cause forces the default NaN. A propagated value is always a quiet NaN. An idle output is clean. The strobe has one cycle of delay. A negative-root flag always traces back to a negative nonzero operand. Which cause goes with which operation code, the ordering between the divide tests, the choice of operand among several signaling NaNs, and the masking of unused operands are shown only by the bench's sweep. That sweep covers every operation code against every triple drawn from a set of zeros, finite values, infinities and NaNs of both signs.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;
  localparam int unsigned N_SRC = 3;   // operands a, b, c
  localparam int unsigned N_MUL = 2;   // operands that take part in cause tests

  localparam logic [3:0] OP_ADD    = 4'd0;
  localparam logic [3:0] OP_SUB    = 4'd1;
  localparam logic [3:0] OP_MUL    = 4'd2;
  localparam logic [3:0] OP_DIV    = 4'd3;
  localparam logic [3:0] OP_SQRT   = 4'd4;
  localparam logic [3:0] OP_RSQRT  = 4'd5;
  localparam logic [3:0] OP_RECIP  = 4'd6;
  localparam logic [3:0] OP_RSP    = 4'd7;
  localparam logic [3:0] OP_FMADD  = 4'd8;
  localparam logic [3:0] OP_FMSUB  = 4'd9;
  localparam logic [3:0] OP_FNMADD = 4'd10;
  localparam logic [3:0] OP_FNMSUB = 4'd11;

  localparam logic [1:0] SEL_PASS = 2'b00;
  localparam logic [1:0] SEL_DFLT = 2'b01;
  localparam logic [1:0] SEL_PROP = 2'b10;

  typedef struct packed {
    logic snan;
    logic inf_sub;
    logic inf_mul_zero;
    logic inf_div;
    logic zero_div;
    logic neg_sqrt;
  } cause_t;

  function automatic logic is_fused(input logic [3:0] op);
    return (op == OP_FMADD) || (op == OP_FMSUB) || (op == OP_FNMADD) || (op == OP_FNMSUB);
  endfunction

  // operands examined per op code
  function automatic logic [N_SRC-1:0] src_mask(input logic [3:0] op);
    logic [N_SRC-1:0] m;
    if (op <= OP_DIV)      m = 3'b011;
    else if (op <= OP_RSP) m = 3'b001;
    else if (is_fused(op)) m = 3'b111;
    else                   m = 3'b000;
    return m;
  endfunction
endpackage

// File: rtl/fpinv_nan_class.sv
module fpinv_nan_class #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output logic                  snan_o,
  output logic [EXP_W+FRAC_W:0] quiet_o
);
  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;

  assign exp_w   = val_i[EXP_W+FRAC_W-1 -: EXP_W];
  assign frac_w  = val_i[FRAC_W-1:0];
  assign snan_o  = (&exp_w) && (|frac_w) && !frac_w[FRAC_W-1];
  // top fraction bit is the quiet marker
  assign quiet_o = {val_i[EXP_W+FRAC_W:FRAC_W], 1'b1, frac_w[FRAC_W-2:0]};
endmodule

// File: rtl/fpinv_special_class.sv
module fpinv_special_class #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output logic                  inf_o,
  output logic                  zero_o,
  output logic                  sign_o
);
  assign sign_o = val_i[EXP_W+FRAC_W];
  assign inf_o  = (&val_i[EXP_W+FRAC_W-1 -: EXP_W]) && (val_i[FRAC_W-1:0] == '0);
  assign zero_o = (val_i[EXP_W+FRAC_W-1:0] == '0);
endmodule

// File: rtl/fpinv_cause_detect.sv
module fpinv_cause_detect
  import fpinv_pkg::*;
(
  input  logic [3:0]       op_i,
  input  logic [N_MUL-1:0] inf_i,
  input  logic [N_MUL-1:0] zero_i,
  input  logic [N_MUL-1:0] sign_i,
  output logic             inf_sub_o,
  output logic             inf_mul_zero_o,
  output logic             inf_div_o,
  output logic             zero_div_o,
  output logic             neg_sqrt_o
);
  logic both_inf, both_zero, inf_zero_pair, same_sign;

  assign both_inf      = inf_i[0] && inf_i[1];
  assign both_zero     = zero_i[0] && zero_i[1];
  assign inf_zero_pair = (inf_i[0] && zero_i[1]) || (zero_i[0] && inf_i[1]);
  assign same_sign     = (sign_i[0] == sign_i[1]);

  always_comb begin
    inf_sub_o      = 1'b0;
    inf_mul_zero_o = 1'b0;
    inf_div_o      = 1'b0;
    zero_div_o     = 1'b0;
    neg_sqrt_o     = 1'b0;
    unique case (op_i)
      OP_ADD:   inf_sub_o = both_inf && !same_sign;
      OP_SUB:   inf_sub_o = both_inf && same_sign;
      OP_MUL:   inf_mul_zero_o = inf_zero_pair;
      OP_DIV: begin
        inf_div_o  = both_inf;
        zero_div_o = !both_inf && both_zero;
      end
      OP_SQRT, OP_RSQRT: neg_sqrt_o = sign_i[0] && !zero_i[0];
      OP_FMADD, OP_FMSUB, OP_FNMADD, OP_FNMSUB: inf_mul_zero_o = inf_zero_pair;
      default: ;
    endcase
  end
endmodule

// File: rtl/fpinv_nan_select.sv
module fpinv_nan_select #(
  parameter int unsigned N      = 3,
  parameter int unsigned DATA_W = 64
) (
  input  logic [N-1:0]             snan_i,
  input  logic [N-1:0]             used_i,
  input  logic [N-1:0][DATA_W-1:0] quiet_i,
  output logic                     hit_o,
  output logic [DATA_W-1:0]        val_o
);
  // scan high to low so the lowest index wins
  always_comb begin
    hit_o = 1'b0;
    val_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (snan_i[i] && used_i[i]) begin
        hit_o = 1'b1;
        val_o = quiet_i[i];
      end
    end
  end
endmodule

// File: rtl/fpinv_classifier.sv
module fpinv_classifier
  import fpinv_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [3:0]            op_i,
  input  logic [EXP_W+FRAC_W:0] src_a_i,
  input  logic [EXP_W+FRAC_W:0] src_b_i,
  input  logic [EXP_W+FRAC_W:0] src_c_i,
  output logic                  valid_o,
  output logic                  inv_snan_o,
  output logic                  inv_inf_sub_o,
  output logic                  inv_inf_mul_zero_o,
  output logic                  inv_inf_div_o,
  output logic                  inv_zero_div_o,
  output logic                  inv_neg_sqrt_o,
  output logic [1:0]            res_sel_o,
  output logic [EXP_W+FRAC_W:0] res_val_o
);
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W;
  localparam logic [DATA_W-1:0] DFLT_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [N_SRC-1:0][DATA_W-1:0] src_v, quiet_v;
  logic [N_SRC-1:0]             snan_v, used_v;
  logic [N_MUL-1:0]             inf_v, zero_v, sign_v;
  logic                         snan_hit;
  logic [DATA_W-1:0]            snan_val;
  cause_t                       cause_c, cause_d, cause_q;
  logic [1:0]                   sel_d, sel_q;
  logic [DATA_W-1:0]            val_d, val_q;
  logic                         vld_q;

  assign src_v  = {src_c_i, src_b_i, src_a_i};
  assign used_v = src_mask(op_i);

  for (genvar g = 0; g < N_SRC; g++) begin : g_nan
    fpinv_nan_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
      .val_i  (src_v[g]),
      .snan_o (snan_v[g]),
      .quiet_o(quiet_v[g])
    );
  end

  for (genvar g = 0; g < N_MUL; g++) begin : g_spec
    fpinv_special_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spec (
      .val_i (src_v[g]),
      .inf_o (inf_v[g]),
      .zero_o(zero_v[g]),
      .sign_o(sign_v[g])
    );
  end

  fpinv_cause_detect u_cause (
    .op_i          (op_i),
    .inf_i         (inf_v),
    .zero_i        (zero_v),
    .sign_i        (sign_v),
    .inf_sub_o     (cause_c.inf_sub),
    .inf_mul_zero_o(cause_c.inf_mul_zero),
    .inf_div_o     (cause_c.inf_div),
    .zero_div_o    (cause_c.zero_div),
    .neg_sqrt_o    (cause_c.neg_sqrt)
  );
  assign cause_c.snan = 1'b0;

  fpinv_nan_select #(.N(N_SRC), .DATA_W(DATA_W)) u_sel (
    .snan_i (snan_v),
    .used_i (used_v),
    .quiet_i(quiet_v),
    .hit_o  (snan_hit),
    .val_o  (snan_val)
  );

  // specific causes outrank signaling NaN
  always_comb begin
    cause_d = '0;
    sel_d   = SEL_PASS;
    val_d   = '0;
    if (valid_i) begin
      if (|cause_c) begin
        cause_d = cause_c;
        sel_d   = SEL_DFLT;
        val_d   = DFLT_QNAN;
      end else if (snan_hit) begin
        cause_d.snan = 1'b1;
        sel_d        = SEL_PROP;
        val_d        = snan_val;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      cause_q <= '0;
      sel_q   <= SEL_PASS;
      val_q   <= '0;
    end else begin
      vld_q   <= valid_i;
      cause_q <= cause_d;
      sel_q   <= sel_d;
      val_q   <= val_d;
    end
  end

  assign valid_o            = vld_q;
  assign inv_snan_o         = cause_q.snan;
  assign inv_inf_sub_o      = cause_q.inf_sub;
  assign inv_inf_mul_zero_o = cause_q.inf_mul_zero;
  assign inv_inf_div_o      = cause_q.inf_div;
  assign inv_zero_div_o     = cause_q.zero_div;
  assign inv_neg_sqrt_o     = cause_q.neg_sqrt;
  assign res_sel_o          = sel_q;
  assign res_val_o          = val_q;
endmodule

// File: rtl/fpinv_classifier_chk.sv
module fpinv_classifier_chk #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [3:0]            op_i,
  input logic [EXP_W+FRAC_W:0] src_a_i,
  input logic                  valid_o,
  input logic                  inv_snan_o,
  input logic                  inv_inf_sub_o,
  input logic                  inv_inf_mul_zero_o,
  input logic                  inv_inf_div_o,
  input logic                  inv_zero_div_o,
  input logic                  inv_neg_sqrt_o,
  input logic [1:0]            res_sel_o,
  input logic [EXP_W+FRAC_W:0] res_val_o
);
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W;
  localparam logic [DATA_W-1:0] DFLT_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [4:0] spec_w;
  logic       live_q;
  assign spec_w = {inv_inf_sub_o, inv_inf_mul_zero_o, inv_inf_div_o, inv_zero_div_o, inv_neg_sqrt_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_FLAGS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({spec_w, inv_snan_o})); // R5

  AST_CAUSE_DFLT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|spec_w) |-> (res_sel_o == 2'b01 && res_val_o == DFLT_QNAN && !inv_snan_o)); // R5

  AST_PROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_snan_o |-> (res_sel_o == 2'b10 && (&res_val_o[DATA_W-2 -: EXP_W]) && res_val_o[FRAC_W-1])); // R6

  AST_PASS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_sel_o == 2'b00) |-> (spec_w == '0 && !inv_snan_o && res_val_o == '0)); // R9

  AST_IDLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (spec_w == '0 && !inv_snan_o && res_sel_o == 2'b00)); // R10

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (valid_o == $past(valid_i))); // R10

  AST_NEG_ROOT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && inv_neg_sqrt_o) |->
      ($past(src_a_i[DATA_W-1]) && $past(src_a_i[DATA_W-2:0]) != '0 && $past(op_i) inside {4'd4, 4'd5})); // R4
endmodule

bind fpinv_classifier fpinv_classifier_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fpinv_classifier_bench.sv
module fpinv_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] DFLT = 64'h7FF8_0000_0000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0, src_c_i = '0;
  logic        valid_o, inv_snan_o, inv_inf_sub_o, inv_inf_mul_zero_o;
  logic        inv_inf_div_o, inv_zero_div_o, inv_neg_sqrt_o;
  logic [1:0]  res_sel_o;
  logic [63:0] res_val_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [63:0] vals [9];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpinv_classifier u_fpinv_classifier (.*);

  function automatic logic is_inf(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] == 0;
  endfunction
  function automatic logic is_zero(input logic [63:0] x);
    return x[62:0] == 0;
  endfunction
  function automatic logic is_snan(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0 && !x[51];
  endfunction

  // flags order: snan, inf_sub, inf_mul_zero, inf_div, zero_div, neg_sqrt
  task automatic model(input logic [3:0] op, input logic [63:0] a, b, c,
                       output logic [5:0] flg, output logic [1:0] sel,
                       output logic [63:0] res, output string tag);
    logic [2:0] use_m;
    logic fused, ia, ib, za, zb;
    logic [63:0] s [3];
    int nsn;
    fused = op >= 8 && op <= 11;
    use_m = op <= 3 ? 3'b011 : op <= 7 ? 3'b001 : fused ? 3'b111 : 3'b000;
    ia = is_inf(a); ib = is_inf(b); za = is_zero(a); zb = is_zero(b);
    flg = '0; sel = 2'b00; res = '0; tag = (op >= 12) ? "R11" : "R9";
    if (op == 0 && ia && ib && a[63] != b[63]) begin flg[4] = 1; tag = "R1"; end
    if (op == 1 && ia && ib && a[63] == b[63]) begin flg[4] = 1; tag = "R1"; end
    if ((op == 2 || fused) && ((ia && zb) || (za && ib))) begin flg[3] = 1; tag = "R2"; end
    if (op == 3 && ia && ib) begin flg[2] = 1; tag = "R3"; end
    else if (op == 3 && za && zb) begin flg[1] = 1; tag = "R3"; end
    if ((op == 4 || op == 5) && a[63] && !za) begin flg[0] = 1; tag = "R4"; end
    if (flg != 0) begin
      sel = 2'b01; res = DFLT;
    end else begin
      s[0] = a; s[1] = b; s[2] = c; nsn = 0;
      for (int i = 2; i >= 0; i--)
        if (use_m[i] && is_snan(s[i])) begin
          nsn++; res = s[i] | 64'h0008_0000_0000_0000;
        end
      if (nsn > 0) begin
        flg[5] = 1; sel = 2'b10; tag = nsn > 1 ? "R7" : "R6";
      end else if ((!use_m[1] && is_snan(b)) || (!use_m[2] && is_snan(c))) tag = "R8";
    end
  endtask

  task automatic check_out(input string tag, input logic ev, input logic [5:0] ef,
                           input logic [1:0] es, input logic [63:0] er);
    logic [5:0] af;
    af = {inv_snan_o, inv_inf_sub_o, inv_inf_mul_zero_o, inv_inf_div_o, inv_zero_div_o, inv_neg_sqrt_o};
    checks++;
    if (valid_o !== ev || af !== ef || res_sel_o !== es || res_val_o !== er) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h c=%h: got v=%b f=%b s=%b r=%h exp v=%b f=%b s=%b r=%h",
               tag, op_i, src_a_i, src_b_i, src_c_i, valid_o, af, res_sel_o, res_val_o,
               ev, ef, es, er);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] ef; logic [1:0] es; logic [63:0] er; string tag;
    vals[0] = 64'h0000_0000_0000_0000; // +0
    vals[1] = 64'h8000_0000_0000_0000; // -0
    vals[2] = 64'h3FF8_0000_0000_0000; // +1.5
    vals[3] = 64'hC000_0000_0000_0000; // -2
    vals[4] = 64'h7FF0_0000_0000_0000; // +inf
    vals[5] = 64'hFFF0_0000_0000_0000; // -inf
    vals[6] = 64'h7FF8_0000_0000_1234; // +qNaN
    vals[7] = 64'hFFF0_0000_0000_00A5; // -sNaN
    vals[8] = 64'h7FF4_0000_0000_0001; // +sNaN

    repeat (3) @(negedge clk_i);
    check_out("R10 reset", 1'b0, '0, 2'b00, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: idle strobe with signaling operands leaves outputs clean
    op_i = 4'd2; src_a_i = vals[8]; src_b_i = vals[7]; valid_i = 1'b0;
    @(negedge clk_i);
    check_out("R10 idle", 1'b0, '0, 2'b00, '0);

    // directed: R6 quieting keeps sign and payload
    op_i = 4'd7; src_a_i = vals[7]; valid_i = 1'b1;
    @(negedge clk_i);
    check_out("R6 rsp", 1'b1, 6'b100000, 2'b10, 64'hFFF8_0000_0000_00A5);
    // directed: R2 fused product test wins over addend sNaN
    op_i = 4'd9; src_a_i = vals[5]; src_b_i = vals[1]; src_c_i = vals[8];
    @(negedge clk_i);
    check_out("R2 fused", 1'b1, 6'b001000, 2'b01, DFLT);
    // directed: R4 negative zero root is clean
    op_i = 4'd4; src_a_i = vals[1];
    @(negedge clk_i);
    check_out("R4 negzero", 1'b1, '0, 2'b00, '0);

    // sweep every op against every operand triple
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 9; ia++)
        for (int ib = 0; ib < 9; ib++)
          for (int ic = 0; ic < 9; ic++) begin
            op_i = 4'(op); src_a_i = vals[ia]; src_b_i = vals[ib]; src_c_i = vals[ic];
            valid_i = 1'b1;
            model(op_i, src_a_i, src_b_i, src_c_i, ef, es, er, tag);
            @(negedge clk_i);
            check_out(tag, 1'b1, ef, es, er);
          end

    valid_i = 1'b0;
    @(negedge clk_i);
    check_out("R10 drain", 1'b0, '0, 2'b00, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule